// File: doc/BRIEF.md
# Serial-Load Latched Display Driver

This block drives a segmented or dot-matrix display with one bit per output channel. A host moves a bit pattern in serially on a slow shift clock, then copies the pattern into a bank of output latches with a level-sensitive load enable. A separate active-low output gate lets all channel outputs through, or forces every channel low at once. The last register stage is brought out as a serial output, so several drivers can share one shift clock and form one long register.

The shift clock, the serial data, the load enable and the gate are slow asynchronous signals. A fast system clock samples all four through a synchronizer chain of configurable depth. A shift happens on the system cycle in which a low-to-high transition of the synchronized shift clock is seen. The data bit used is the one sampled alongside that transition. The synchronizer flops reset to logic high, which is the value an unconnected input must be taken to have. As a result, an idle driver comes out of reset blanked.

Top module: `vfd_shift_driver`

## Requirements
- R1: On each detected rising edge of the shift clock, stage 1 (bit 0) of the NCH-stage register takes the serial input, and each stage n+1 (bit n) takes the earlier value of stage n.
- R2: Only a low-to-high transition of the shift clock shifts. A shift clock held high, held low, or falling leaves the register unchanged.
- R3: While the load enable is high, the latches follow the register, including the value written by a shift on that same cycle.
- R4: While the load enable is low, the latches hold their value whatever the register does.
- R5: While the gate input is high, every bit of drive_out is 0. While it is low, drive_out[i] equals latch i, which holds stage i+1.
- R6: ser_out always equals the last register stage (bit NCH-1). It ignores the load enable and the gate.
- R7: A synchronous active-high reset clears the register and the latches to zero. The gate keeps control of the outputs during and after reset.
- R8: An input change applied before system clock edge k reaches the synchronized domain after edge k+SYNC_STAGES-1. A gate change therefore shows on drive_out after that edge, and a shift-clock rise updates the register at edge k+SYNC_STAGES.
- R9: The synchronizer flops reset to 1. With all inputs held high through reset and after it, the driver stays blanked and no shift occurs when reset is released.
- R10: With ser_out of one driver feeding ser_in of the next on a shared shift clock, two drivers act as one 2*NCH-stage register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all control inputs |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Asynchronous shift clock; its rising edges shift the register |
| ser_in | input | 1 | Serial data input |
| load_en | input | 1 | Level-sensitive latch enable; high makes the latches transparent |
| gate_n | input | 1 | Active-low output gate; high forces all outputs low |
| drive_out | output | NCH | Gated parallel channel outputs |
| ser_out | output | 1 | Last register stage, used for cascading |

## Verification
The bench builds two drivers with NCH = 12 and SYNC_STAGES = 2, with the serial output of the first feeding the second. This makes the 24-stage cascade and the stage-to-stage hand-off between devices observable. The two-stage synchronizer gives a short, fixed input-to-output latency, so gate timing and shift timing can be checked edge by edge. Shift-clock levels are held for four system cycles, long enough that each device sees its neighbour's settled serial output.

// File: rtl/vfd_shift_driver.sv
module vfd_shift_driver #(
  parameter int NCH         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_clk,
  input  logic           ser_in,
  input  logic           load_en,
  input  logic           gate_n,
  output logic [NCH-1:0] drive_out,
  output logic           ser_out
);
  localparam int NIN = 4;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] synced;
  logic           s_clk, s_din, s_le, s_gate_n;
  logic           clk_prev;
  logic           rise;
  logic [NCH-1:0] sr, sr_next, lat;

  assign raw_in = {gate_n, load_en, ser_in, shift_clk};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) sync_q[g] <= '1;
        else     sync_q[g] <= raw_in;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) sync_q[g] <= '1;
        else     sync_q[g] <= sync_q[g-1];
    end
  end

  assign synced   = sync_q[SYNC_STAGES-1];
  assign s_clk    = synced[0];
  assign s_din    = synced[1];
  assign s_le     = synced[2];
  assign s_gate_n = synced[3];

  always_ff @(posedge clk)
    if (rst) clk_prev <= 1'b1;
    else     clk_prev <= s_clk;

  assign rise    = s_clk & ~clk_prev;
  assign sr_next = rise ? {sr[NCH-2:0], s_din} : sr;

  always_ff @(posedge clk)
    if (rst) begin
      sr  <= '0;
      lat <= '0;
    end else begin
      sr <= sr_next;
      if (s_le) lat <= sr_next;
    end

  assign drive_out = s_gate_n ? '0 : lat;
  assign ser_out   = sr[NCH-1];
endmodule

// File: rtl/vfd_shift_driver_chk.sv
module vfd_shift_driver_chk #(
  parameter int NCH         = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           gate_n,
  input logic [NCH-1:0] drive_out,
  input logic           ser_out,
  input logic           rise,
  input logic           s_din,
  input logic           s_le,
  input logic [NCH-1:0] sr,
  input logic [NCH-1:0] lat
);
  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> sr == {$past(sr[NCH-2:0]), $past(s_din)});

  assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
    s_le |=> lat == sr);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !s_le |=> $stable(lat));

  assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
    $past(gate_n, SYNC_STAGES) |-> drive_out == '0);

  assert_cascade_R6: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(ser_out));

  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (sr == '0 && lat == '0));
endmodule

bind vfd_shift_driver vfd_shift_driver_chk #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .gate_n(gate_n), .drive_out(drive_out), .ser_out(ser_out),
  .rise(rise), .s_din(s_din), .s_le(s_le), .sr(sr), .lat(lat)
);

// File: tb/vfd_shift_driver_bench.sv
module vfd_shift_driver_bench;
  localparam int N = 12;
  localparam int S = 2;

  logic clk = 0;
  logic rst = 1;
  logic sc = 1, d = 1, le = 1, gn = 1;
  logic [N-1:0] drv0, drv1;
  logic ser0, ser1;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vfd_shift_driver #(.NCH(N), .SYNC_STAGES(S)) u_vfd_shift_driver (
    .clk(clk), .rst(rst), .shift_clk(sc), .ser_in(d), .load_en(le), .gate_n(gn),
    .drive_out(drv0), .ser_out(ser0));

  vfd_shift_driver #(.NCH(N), .SYNC_STAGES(S)) u_vfd_shift_driver_next (
    .clk(clk), .rst(rst), .shift_clk(sc), .ser_in(ser0), .load_en(le), .gate_n(gn),
    .drive_out(drv1), .ser_out(ser1));

  bit h_sc[8], h_d[8], h_le[8], h_gn[8];
  logic [2*N-1:0] m_sr = '0, m_lat = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [2*N-1:0] nsr;
    for (int i = 7; i > 0; i--) begin
      h_sc[i] = h_sc[i-1]; h_d[i] = h_d[i-1]; h_le[i] = h_le[i-1]; h_gn[i] = h_gn[i-1];
    end
    if (rst) begin
      h_sc[0] = 1; h_d[0] = 1; h_le[0] = 1; h_gn[0] = 1;
      m_sr = '0; m_lat = '0;
    end else begin
      h_sc[0] = sc; h_d[0] = d; h_le[0] = le; h_gn[0] = gn;
      nsr = m_sr;
      if (h_sc[S] && !h_sc[S+1]) nsr = {m_sr[2*N-2:0], h_d[S]};
      if (h_le[S]) m_lat = nsr;
      m_sr = nsr;
    end
  endtask

  task automatic cyc(logic c, logic dd, logic l, logic g);
    sc = c; d = dd; le = l; gn = g;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R5 drive0", 32'(drv0), h_gn[S-1] ? 32'd0 : 32'(m_lat[N-1:0]));
    check("R10 drive1", 32'(drv1), h_gn[S-1] ? 32'd0 : 32'(m_lat[2*N-1:N]));
    check("R6 ser0", 32'(ser0), 32'(m_sr[N-1]));
    check("R10 ser1", 32'(ser1), 32'(m_sr[2*N-1]));
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) cyc(sc, d, le, gn);
  endtask

  task automatic shift_bit(logic b, logic l, logic g);
    for (int i = 0; i < 4; i++) cyc(0, b, l, g);
    for (int i = 0; i < 4; i++) cyc(1, b, l, g);
  endtask

  task automatic shift_word(logic [2*N-1:0] w, logic l, logic g);
    for (int i = 2*N-1; i >= 0; i--) shift_bit(w[i], l, g);
  endtask

  localparam logic [2*N-1:0] PAT1 = 24'h5A3C96;
  localparam logic [2*N-1:0] PAT2 = 24'h3C69A5;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin h_sc[i] = 1; h_d[i] = 1; h_le[i] = 1; h_gn[i] = 1; end
    @(negedge clk);
    rst = 1;
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1);
    check("R7 reset drive blank", 32'(drv0), 0);
    rst = 0;
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, 1);
    check("R9 no shift on release", 32'(ser0), 0);
    check("R9 still blanked", 32'(drv0), 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    check("R7 latches cleared", 32'({drv1, drv0}), 0);

    shift_word(PAT1, 1, 0);
    hold(4);
    check("R1 chip0 pattern", 32'(drv0), 32'(PAT1[N-1:0]));
    check("R10 chip1 pattern", 32'(drv1), 32'(PAT1[2*N-1:N]));
    check("R6 ser0 last stage", 32'(ser0), 32'(PAT1[N-1]));

    shift_word(PAT2, 0, 0);
    hold(4);
    check("R4 latches held", 32'({drv1, drv0}), 32'(PAT1));
    check("R6 ser1 ignores enable", 32'(ser1), 32'(PAT2[2*N-1]));

    cyc(sc, d, 0, 1); cyc(sc, d, 0, 1); hold(2);
    check("R5 gate blanks", 32'({drv1, drv0}), 0);
    check("R6 ser0 ignores gate", 32'(ser0), 32'(PAT2[N-1]));
    cyc(sc, d, 0, 0);
    check("R8 gate not yet seen", 32'(drv0), 0);
    cyc(sc, d, 0, 0);
    check("R8 gate seen after S edges", 32'(drv0), 32'(PAT1[N-1:0]));

    cyc(sc, d, 1, 0); hold(3); cyc(sc, d, 0, 0); hold(3);
    check("R3 enable pulse loads", 32'({drv1, drv0}), 32'(PAT2));

    le = 1;
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0);
    check("R2 no shift on hold or fall", 32'({drv1, drv0}), 32'(PAT2));

    cyc(1, 1, 1, 0);
    cyc(1, 1, 1, 0);
    check("R8 shift not before S edges", 32'({drv1, drv0}), 32'(PAT2));
    cyc(1, 1, 1, 0);
    check("R3 shift passes through", 32'({drv1, drv0}), 32'({PAT2[2*N-2:0], 1'b1}));
    check("R1 stage1 takes data", 32'(drv0[0]), 1);

    rst = 1;
    cyc(1, 1, 1, 0);
    rst = 0;
    hold(3);
    check("R7 reset clears", 32'({drv1, drv0}), 0);
    check("R7 reset clears ser", 32'({ser1, ser0}), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule